// File: doc/BRIEF.md
# Dual-Core Power Mode Controller

This block sequences the power state of a two-core system. Each core may fall asleep on its own when it signals a wait-for-interrupt or wait-for-event instruction. While asleep its clock is gated off and the rest of the chip keeps running. An interrupt or event aimed at that core reopens its clock. Neither core's sleep or wake affects the other.

The whole system drops into one of three power-down levels once every core that holds a power-down enable has gone to sleep. The levels are deep-sleep, power-down and deep power-down. A core without the enable is left out of that decision. The level is taken from a two-bit request at the moment of entry and is then held. While the system is powered down, ordinary core wake lines are ignored. Only a wake pin or the real-time-clock alarm line brings the system back, and both pass through a two-flip-flop synchroniser. Leaving deep power-down also raises a one-cycle system reset request so that the device reboots.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, sys_mode_o is 0 (active), every core_clk_en_o bit is 1 and sys_rst_req_o is 0.
- R2: A high core_sleep_req_i[i] on an awake core, with core_wake_i[i] low, clears core_clk_en_o[i] after the next clock edge. The other core's clock enable is unchanged.
- R3: A high core_wake_i[i] on a sleeping core sets core_clk_en_o[i] again after the next clock edge. A wake to an awake core has no effect. A sleep request that comes with a wake in the same cycle leaves the core awake.
- R4: The sys_mode_o encoding is 0 active, 1 deep-sleep, 2 power-down and 3 deep power-down. The system enters a power-down level when three things hold: pd_mode_sel_i is non-zero, at least one core_pd_en_i bit is set, and every enabled core is asleep. sys_mode_o then takes the value of pd_mode_sel_i one clock edge after the last enabled core is registered as asleep.
- R5: A core whose core_pd_en_i bit is 0 is ignored by the entry check, so the system enters even while that core runs. With no enable bit set, or with pd_mode_sel_i at 0, the system never enters power-down.
- R6: Once powered down, sys_mode_o stays at the latched level while pd_mode_sel_i changes.
- R7: While powered down, core_wake_i and core_sleep_req_i have no effect on sys_mode_o or on the clock enables.
- R8: A high level on any wakeup_pin_i bit or on rtc_wake_i while powered down returns sys_mode_o to 0 on the third clock edge after the input changes. All core clock enables are 1 from that edge on.
- R9: sys_rst_req_o is high for exactly one cycle, the cycle in which sys_mode_o has just returned to 0 from 3. It stays 0 on exit from levels 1 and 2.
- R10: In every power-down level all core_clk_en_o bits are 0.
- R11: wakeup_pin_i and rtc_wake_i have no effect while the system is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_sleep_req_i | input | NUM_CORES | Per-core wait-for-interrupt/event indication |
| core_pd_en_i | input | NUM_CORES | Per-core permission to take the system into power-down |
| core_wake_i | input | NUM_CORES | Per-core interrupt or event wake, synchronous |
| pd_mode_sel_i | input | 2 | Requested power-down level, 0 meaning core sleep only |
| wakeup_pin_i | input | NUM_WAKE_PINS | Asynchronous wake pins, level-sensitive |
| rtc_wake_i | input | 1 | Asynchronous RTC/alarm wake, level-sensitive |
| core_clk_en_o | output | NUM_CORES | Per-core clock enable |
| sys_mode_o | output | 2 | Current system power level |
| sys_rst_req_o | output | 1 | One-cycle reboot request after deep power-down |

## Verification
Core sleep and wake results appear one clock edge after the request, because the clock enable is decoded straight from the per-core state register. Entry into power-down lands one edge after the last enabled core's sleep is registered, which is two edges after that core's request. Pin and alarm wakes need three edges: two synchroniser stages and the mode register. The reset request and the reopened clocks appear on that same third edge, and the reset request falls on the fourth. The driver tags each expected output with the cycle index on which it is due. The monitor compares it half a period after that edge, so a result one cycle early or late is flagged as a mismatch.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE     = 2'd0,
    MODE_DEEP_SLEEP = 2'd1,
    MODE_PWR_DOWN   = 2'd2,
    MODE_DEEP_PD    = 2'd3
  } sys_mode_e;

  localparam int unsigned MAX_CORES = 32;

  // True when at least one core is enabled and all enabled cores sleep.
  function automatic logic pd_ready(input logic [MAX_CORES-1:0] asleep,
                                    input logic [MAX_CORES-1:0] en);
    return (|en) && ((asleep & en) == en);
  endfunction

  // A non-zero level names a power-down state.
  function automatic logic is_pd_level(input logic [1:0] lvl);
    return lvl != 2'd0;
  endfunction

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_core_state.sv
module pmc_core_state (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic wake_i,
  input  logic sys_active_i,
  input  logic pd_exit_i,
  output logic asleep_o,
  output logic clk_en_o
);

  logic asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
    end else if (pd_exit_i) begin
      asleep_q <= 1'b0;
    end else if (sys_active_i) begin
      if (asleep_q && wake_i)
        asleep_q <= 1'b0;
      else if (!asleep_q && sleep_req_i && !wake_i)
        asleep_q <= 1'b1;
    end
  end

  assign asleep_o = asleep_q;
  assign clk_en_o = !asleep_q && sys_active_i;

  // R2: a granted sleep closes the clock on the next cycle
  a_r2_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_active_i && !asleep_o && sleep_req_i && !wake_i) |=> !clk_en_o);

  // R3: a wake to a sleeping core in active system clears the sleep state
  a_r3_wake_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_active_i && asleep_o && wake_i) |=> !asleep_o);

  // R3: a simultaneous wake keeps an awake core awake
  a_r3_wake_beats_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_active_i && !asleep_o && wake_i) |=> !asleep_o);

endmodule

// File: rtl/pmc_sys_fsm.sv
module pmc_sys_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] asleep_i,
  input  logic [NUM_CORES-1:0] pd_en_i,
  input  logic [1:0]           mode_sel_i,
  input  logic                 wake_any_i,
  output sys_mode_e            sys_mode_o,
  output logic                 pd_entry_o,
  output logic                 pd_exit_o,
  output logic                 rst_req_o
);

  sys_mode_e mode_q;
  logic      rst_req_q;
  logic      ready_w;

  assign ready_w    = pd_ready(MAX_CORES'(asleep_i), MAX_CORES'(pd_en_i));
  assign pd_entry_o = (mode_q == MODE_ACTIVE) && is_pd_level(mode_sel_i) && ready_w;
  assign pd_exit_o  = (mode_q != MODE_ACTIVE) && wake_any_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_ACTIVE;
      rst_req_q <= 1'b0;
    end else begin
      if (pd_entry_o)     mode_q <= sys_mode_e'(mode_sel_i);
      else if (pd_exit_o) mode_q <= MODE_ACTIVE;
      rst_req_q <= pd_exit_o && (mode_q == MODE_DEEP_PD);
    end
  end

  assign sys_mode_o = mode_q;
  assign rst_req_o  = rst_req_q;

  // R4/R5: leaving active requires every enabled core to have been asleep
  a_r4_entry_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sys_mode_o) == MODE_ACTIVE && sys_mode_o != MODE_ACTIVE) |->
      ($past(|pd_en_i) && $past((asleep_i & pd_en_i) == pd_en_i)));

  // R6/R7: a powered-down level holds until a wake arrives
  a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o != MODE_ACTIVE && !wake_any_i) |=> $stable(sys_mode_o));

  // R9: reboot request only right after deep power-down
  a_r9_rst_after_deep: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> ($past(sys_mode_o) == MODE_DEEP_PD && sys_mode_o == MODE_ACTIVE));

  // R9: reboot request is a single-cycle pulse
  a_r9_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  // R11: wake lines do not move an active system
  a_r11_active_ignores_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o == MODE_ACTIVE && !pd_entry_o) |=> sys_mode_o == MODE_ACTIVE);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_CORES     = 2,
  parameter int unsigned NUM_WAKE_PINS = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CORES-1:0]     core_sleep_req_i,
  input  logic [NUM_CORES-1:0]     core_pd_en_i,
  input  logic [NUM_CORES-1:0]     core_wake_i,
  input  logic [1:0]               pd_mode_sel_i,
  input  logic [NUM_WAKE_PINS-1:0] wakeup_pin_i,
  input  logic                     rtc_wake_i,
  output logic [NUM_CORES-1:0]     core_clk_en_o,
  output logic [1:0]               sys_mode_o,
  output logic                     sys_rst_req_o
);

  localparam int unsigned WAKE_W = NUM_WAKE_PINS + 1;

  logic [WAKE_W-1:0]    wake_sync_w;
  logic                 wake_any_w;
  logic [NUM_CORES-1:0] asleep_w;
  logic                 pd_entry_w;
  logic                 pd_exit_w;
  logic                 sys_active_w;
  sys_mode_e            mode_w;

  pmc_wake_sync #(
    .WIDTH  (WAKE_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({rtc_wake_i, wakeup_pin_i}),
    .sync_o  (wake_sync_w)
  );

  assign wake_any_w = |wake_sync_w;

  pmc_sys_fsm #(
    .NUM_CORES (NUM_CORES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .asleep_i   (asleep_w),
    .pd_en_i    (core_pd_en_i),
    .mode_sel_i (pd_mode_sel_i),
    .wake_any_i (wake_any_w),
    .sys_mode_o (mode_w),
    .pd_entry_o (pd_entry_w),
    .pd_exit_o  (pd_exit_w),
    .rst_req_o  (sys_rst_req_o)
  );

  assign sys_active_w = (mode_w == MODE_ACTIVE);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pmc_core_state u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req_i  (core_sleep_req_i[c]),
      .wake_i       (core_wake_i[c]),
      .sys_active_i (sys_active_w),
      .pd_exit_i    (pd_exit_w),
      .asleep_o     (asleep_w[c]),
      .clk_en_o     (core_clk_en_o[c])
    );
  end

  assign sys_mode_o = mode_w;

  // R10: no core clock runs in a power-down level
  a_r10_gated_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o != 2'd0) |-> (core_clk_en_o == '0));

  // R8: leaving power-down reopens every core clock
  a_r8_exit_all_awake: assert property (@(posedge clk) disable iff (!rst_n)
    pd_exit_w |=> (core_clk_en_o == '1));

  // entry and exit never coincide
  a_r4_entry_exit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_entry_w && pd_exit_w));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sleep_req = '0;
  logic [1:0] pd_en = '0;
  logic [1:0] cwake = '0;
  logic [1:0] mode_sel = '0;
  logic [3:0] wpin = '0;
  logic       rtc = 1'b0;
  logic [1:0] clk_en;
  logic [1:0] mode;
  logic       rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    int         due;
    string      tag;
    logic [1:0] ce;
    logic [1:0] md;
    logic       rr;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .core_sleep_req_i (sleep_req),
    .core_pd_en_i     (pd_en),
    .core_wake_i      (cwake),
    .pd_mode_sel_i    (mode_sel),
    .wakeup_pin_i     (wpin),
    .rtc_wake_i       (rtc),
    .core_clk_en_o    (clk_en),
    .sys_mode_o       (mode),
    .sys_rst_req_o    (rst_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due items half a period after their edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_tests++;
      if (e.due != cyc || clk_en !== e.ce || mode !== e.md || rst_req !== e.rr) begin
        n_fail++;
        $display("FAIL %s cyc=%0d: actual clk_en=%b mode=%0d rst=%b expected clk_en=%b mode=%0d rst=%b",
                 e.tag, cyc, clk_en, mode, rst_req, e.ce, e.md, e.rr);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_at(input int d, input string tag, input logic [1:0] ce,
                           input logic [1:0] md, input logic rr);
    exp_t x;
    x.due = cyc + d; x.tag = tag; x.ce = ce; x.md = md; x.rr = rr;
    q.push_back(x);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1 reset state
    expect_at(1, "R1 reset", 2'b11, 2'd0, 1'b0);
    tick();

    // R2 core0 sleeps, core1 unaffected
    sleep_req = 2'b01;
    expect_at(1, "R2 sleep core0", 2'b10, 2'd0, 1'b0);
    tick(); sleep_req = '0;

    // R3 wake reopens; wake to awake core; wake beats sleep
    cwake = 2'b01;
    expect_at(1, "R3 wake core0", 2'b11, 2'd0, 1'b0);
    tick();
    cwake = 2'b10;
    expect_at(1, "R3 wake awake core1", 2'b11, 2'd0, 1'b0);
    tick();
    cwake = 2'b10; sleep_req = 2'b10;
    expect_at(1, "R3 wake with sleep", 2'b11, 2'd0, 1'b0);
    tick(); cwake = '0; sleep_req = '0;

    // R5 no enable bit: no entry
    mode_sel = 2'd2; pd_en = 2'b00; sleep_req = 2'b11;
    expect_at(1, "R5 both asleep no enable", 2'b00, 2'd0, 1'b0);
    tick(); sleep_req = '0;
    expect_at(1, "R5 stays active", 2'b00, 2'd0, 1'b0);
    tick();
    cwake = 2'b11;
    expect_at(1, "R3 wake both", 2'b11, 2'd0, 1'b0);
    tick(); cwake = '0;

    // R4 entry after both enabled cores sleep, deep-sleep level
    pd_en = 2'b11; mode_sel = 2'd1; sleep_req = 2'b01;
    expect_at(1, "R4 first core asleep no entry", 2'b10, 2'd0, 1'b0);
    tick(); sleep_req = 2'b10;
    expect_at(1, "R4 last core asleep", 2'b00, 2'd0, 1'b0);
    expect_at(2, "R4 enter deep-sleep", 2'b00, 2'd1, 1'b0);
    tick(); sleep_req = '0;
    tick();

    // R6 level latched
    mode_sel = 2'd3;
    expect_at(1, "R6 level held", 2'b00, 2'd1, 1'b0);
    tick();
    // R7 core wakes ignored in power-down
    cwake = 2'b11; sleep_req = 2'b11;
    expect_at(1, "R7 core wake ignored", 2'b00, 2'd1, 1'b0);
    tick(); cwake = '0; sleep_req = '0;

    // R8 pin wake, three edges; R9 no reset from deep-sleep
    wpin = 4'b0100;
    expect_at(1, "R8 sync stage1", 2'b00, 2'd1, 1'b0);
    expect_at(2, "R8 sync stage2", 2'b00, 2'd1, 1'b0);
    expect_at(3, "R8 pin wake exit", 2'b11, 2'd0, 1'b0);
    expect_at(4, "R9 no reset after deep-sleep", 2'b11, 2'd0, 1'b0);
    tick(); wpin = '0;
    flush(4);

    // R5 core1 not enabled and awake, entry to deep power-down
    pd_en = 2'b01; sleep_req = 2'b01;
    expect_at(1, "R5 core0 asleep core1 runs", 2'b10, 2'd0, 1'b0);
    expect_at(2, "R5 enter deep pd ignoring core1", 2'b00, 2'd3, 1'b0);
    tick(); sleep_req = '0;
    tick();
    // R8 RTC wake, R9 reset pulse
    rtc = 1'b1;
    expect_at(1, "R10 clocks gated deep pd", 2'b00, 2'd3, 1'b0);
    expect_at(3, "R9 reset on deep pd exit", 2'b11, 2'd0, 1'b1);
    expect_at(4, "R9 reset single cycle", 2'b11, 2'd0, 1'b0);
    tick(); rtc = 1'b0;
    flush(4);

    // R11 wake lines ignored while active
    wpin = 4'b1001;
    expect_at(3, "R11 pin in active", 2'b11, 2'd0, 1'b0);
    tick(); wpin = '0;
    flush(4);

    // R10 power-down level 2, both cores at once
    pd_en = 2'b11; mode_sel = 2'd2; sleep_req = 2'b11;
    expect_at(1, "R4 both asleep together", 2'b00, 2'd0, 1'b0);
    expect_at(2, "R10 power-down gated", 2'b00, 2'd2, 1'b0);
    tick(); sleep_req = '0;
    tick();
    rtc = 1'b1;
    expect_at(3, "R9 no reset after power-down", 2'b11, 2'd0, 1'b0);
    tick(); rtc = 1'b0;
    flush(4);

    while (q.size() > 0) tick();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-reqs: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule